// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles whether a control-transfer instruction changes the flow of execution and where the next instruction is. It takes a 4-bit condition code, the five status flags (sign, zero, parity, carry, overflow), the program counter of the branch, the length of the branch instruction, a signed relative displacement and a count value. It returns a taken decision and the next program counter. The same result is first available combinationally. A registered copy follows one cycle after an evaluate strobe.

A 2-bit kind input selects one of four forms. The first is a plain flag-tested jump. The second is a count loop that decrements the count and branches while the result is nonzero. The third is a jump taken when the count is already zero. The fourth is a count loop that also requires the flag condition to hold. Bit 0 of the condition code inverts the base test picked by bits 3:1. Signed ordering tests are built from sign, overflow and zero. Unsigned ordering tests are built from carry and zero.

Top module: `branch_resolver`

## Requirements
- R1: With kind 0, code 9 is always taken and code 8 is never taken, whatever the flags are.
- R2: With kind 0, the single-flag codes are: 0 zero set, 1 zero clear, 2 carry set, 3 carry clear, 4 overflow set, 5 overflow clear, 6 parity set, 7 parity clear.
- R3: With kind 0, the signed codes are: 10 less (sign XOR overflow), 11 greater-or-equal (its inverse), 12 less-or-equal (sign XOR overflow, OR zero), 13 greater (its inverse).
- R4: With kind 0, the unsigned codes are: 2 below (carry), 3 above-or-equal (no carry), 14 below-or-equal (carry OR zero), 15 above (neither carry nor zero).
- R5: The next PC is pc + len when not taken, and pc + len + sign-extended displacement when taken, all modulo 2^PC_W.
- R6: With kind 1, the count output is count - 1 (0 wraps to all ones), and the branch is taken exactly when that result is nonzero; the condition code and flags have no effect.
- R7: With kind 2, the branch is taken exactly when the count input is zero, and the count output equals the count input.
- R8: With kind 3, the count output is count - 1, and the branch is taken exactly when that result is nonzero and the condition code (as in R1 to R4) holds.
- R9: One cycle after eval_i is high, valid_o is high and taken_o, next_pc_o and count_o hold the combinational results of that evaluation. Without eval_i, valid_o is low and the registered outputs keep their values.
- R10: During synchronous reset, valid_o, taken_o, next_pc_o and count_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe; captures the result |
| kind_i | input | 2 | 0 flag jump, 1 loop, 2 jump if count zero, 3 loop with condition |
| cond_i | input | 4 | Condition code |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_p_i | input | 1 | Parity flag |
| flag_c_i | input | 1 | Carry flag |
| flag_o_i | input | 1 | Overflow flag |
| pc_i | input | PC_W | Address of the branch instruction |
| len_i | input | LEN_W | Length of the branch instruction |
| disp_i | input | DISP_W | Signed relative displacement |
| count_i | input | CNT_W | Current count register value |
| taken_c_o | output | 1 | Combinational taken decision |
| next_pc_c_o | output | PC_W | Combinational next PC |
| count_c_o | output | CNT_W | Combinational updated count |
| valid_o | output | 1 | Registered result valid, one cycle after eval_i |
| taken_o | output | 1 | Registered taken decision |
| next_pc_o | output | PC_W | Registered next PC |
| count_o | output | CNT_W | Registered updated count |

## Verification
The properties assume that every input holds a known value from the first clock after reset. They also assume that inputs change only between clock edges, so the combinational result sampled at an edge belongs to the same evaluation the strobe captures. Every kind and code value is legal, so no property limits them. The stimulus drives all inputs at the falling edge from time zero. It covers every code against all 32 flag patterns, the count values 0, 1 and 2 in each count form, and displacements that wrap the address in both directions.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [1:0] {
    KIND_FLAG  = 2'd0,
    KIND_LOOP  = 2'd1,
    KIND_CZERO = 2'd2,
    KIND_LOOPC = 2'd3
  } kind_e;

  // base test chosen by cond[3:1]; cond[0] inverts it
  typedef enum logic [2:0] {
    TST_ZERO  = 3'd0,
    TST_CARRY = 3'd1,
    TST_OVF   = 3'd2,
    TST_PAR   = 3'd3,
    TST_NEVER = 3'd4,
    TST_SLT   = 3'd5,
    TST_SLE   = 3'd6,
    TST_BE    = 3'd7
  } test_e;

endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
  import brx_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       fs,
  input  logic       fz,
  input  logic       fp,
  input  logic       fc,
  input  logic       fo,
  output logic       hold
);

  test_e base_sel;
  logic  base_val;
  logic  sgn_lt;

  assign base_sel = test_e'(cond[3:1]);
  assign sgn_lt   = fs ^ fo;

  always_comb begin
    unique case (base_sel)
      TST_ZERO:  base_val = fz;
      TST_CARRY: base_val = fc;
      TST_OVF:   base_val = fo;
      TST_PAR:   base_val = fp;
      TST_NEVER: base_val = 1'b0;
      TST_SLT:   base_val = sgn_lt;
      TST_SLE:   base_val = sgn_lt | fz;
      TST_BE:    base_val = fc | fz;
      default:   base_val = 1'b0;
    endcase
  end

  assign hold = base_val ^ cond[0];

endmodule

// File: rtl/brx_decide.sv
module brx_decide
  import brx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       kind,
  input  logic             cond_hold,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             taken,
  output logic [CNT_W-1:0] cnt_out
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_dec;
  logic             dec_live;
  logic             cnt_empty;

  assign cnt_dec   = cnt_in - CNT_ONE;
  assign dec_live  = |cnt_dec;
  assign cnt_empty = ~|cnt_in;

  always_comb begin
    unique case (kind_e'(kind))
      KIND_FLAG: begin
        taken   = cond_hold;
        cnt_out = cnt_in;
      end
      KIND_LOOP: begin
        taken   = dec_live;
        cnt_out = cnt_dec;
      end
      KIND_CZERO: begin
        taken   = cnt_empty;
        cnt_out = cnt_in;
      end
      KIND_LOOPC: begin
        taken   = dec_live & cond_hold;
        cnt_out = cnt_dec;
      end
      default: begin
        taken   = 1'b0;
        cnt_out = cnt_in;
      end
    endcase
  end

endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int PC_W   = 32,
  parameter int LEN_W  = 4,
  parameter int DISP_W = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   next_pc
);

  logic [PC_W-1:0] fall_thru;
  logic [PC_W-1:0] disp_ext;

  generate
    if (DISP_W >= PC_W) begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end else begin : g_sext
      assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    end
  endgenerate

  assign fall_thru = pc + PC_W'(len);
  assign next_pc   = taken ? (fall_thru + disp_ext) : fall_thru;

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int PC_W   = 32,
  parameter int LEN_W  = 4,
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic              flag_s_i,
  input  logic              flag_z_i,
  input  logic              flag_p_i,
  input  logic              flag_c_i,
  input  logic              flag_o_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              taken_c_o,
  output logic [PC_W-1:0]   next_pc_c_o,
  output logic [CNT_W-1:0]  count_c_o,
  output logic              valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [CNT_W-1:0]  count_o
);

  logic cond_hold;

  brx_cond_eval u_cond (
    .cond (cond_i),
    .fs   (flag_s_i),
    .fz   (flag_z_i),
    .fp   (flag_p_i),
    .fc   (flag_c_i),
    .fo   (flag_o_i),
    .hold (cond_hold)
  );

  brx_decide #(.CNT_W(CNT_W)) u_decide (
    .kind      (kind_i),
    .cond_hold (cond_hold),
    .cnt_in    (count_i),
    .taken     (taken_c_o),
    .cnt_out   (count_c_o)
  );

  brx_target #(.PC_W(PC_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_target (
    .pc      (pc_i),
    .len     (len_i),
    .disp    (disp_i),
    .taken   (taken_c_o),
    .next_pc (next_pc_c_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      count_o   <= '0;
    end else begin
      valid_o <= eval_i;
      if (eval_i) begin
        taken_o   <= taken_c_o;
        next_pc_o <= next_pc_c_o;
        count_o   <= count_c_o;
      end
    end
  end

endmodule

// File: rtl/brx_checker.sv
module brx_checker #(
  parameter int PC_W   = 32,
  parameter int LEN_W  = 4,
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              eval_i,
  input logic [1:0]        kind_i,
  input logic [3:0]        cond_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              taken_c_o,
  input logic [PC_W-1:0]   next_pc_c_o,
  input logic [CNT_W-1:0]  count_c_o,
  input logic              valid_o,
  input logic              taken_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic [CNT_W-1:0]  count_o
);

  assert_always_taken_R1: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'd0 && cond_i == 4'd9) |-> taken_c_o);

  assert_never_taken_R1: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'd0 && cond_i == 4'd8) |-> !taken_c_o);

  assert_fallthru_R5: assert property (@(posedge clk) disable iff (rst)
    !taken_c_o |-> (next_pc_c_o == pc_i + PC_W'(len_i)));

  assert_czero_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (kind_i == 2'd2) |-> (count_c_o == count_i && taken_c_o == (count_i == '0)));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> valid_o);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> !valid_o);

  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> (taken_o == $past(taken_c_o) && next_pc_o == $past(next_pc_c_o)
                && count_o == $past(count_c_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> ($stable(taken_o) && $stable(next_pc_o) && $stable(count_o)));

endmodule

bind branch_resolver brx_checker #(
  .PC_W(PC_W), .LEN_W(LEN_W), .DISP_W(DISP_W), .CNT_W(CNT_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .eval_i      (eval_i),
  .kind_i      (kind_i),
  .cond_i      (cond_i),
  .pc_i        (pc_i),
  .len_i       (len_i),
  .count_i     (count_i),
  .taken_c_o   (taken_c_o),
  .next_pc_c_o (next_pc_c_o),
  .count_c_o   (count_c_o),
  .valid_o     (valid_o),
  .taken_o     (taken_o),
  .next_pc_o   (next_pc_o),
  .count_o     (count_o)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;

  localparam int PC_W = 32, LEN_W = 4, DISP_W = 16, CNT_W = 16;

  typedef struct {
    logic            tk;
    logic [PC_W-1:0] npc;
    logic [CNT_W-1:0] cnt;
    string           req;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, eval_i = 1'b0;
  logic [1:0] kind_i = '0;
  logic [3:0] cond_i = '0;
  logic flag_s_i = 0, flag_z_i = 0, flag_p_i = 0, flag_c_i = 0, flag_o_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [DISP_W-1:0] disp_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic taken_c_o, valid_o, taken_o;
  logic [PC_W-1:0] next_pc_c_o, next_pc_o;
  logic [CNT_W-1:0] count_c_o, count_o;

  int checks = 0, failures = 0, pulses = 0, pushes = 0;
  exp_t sb[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  branch_resolver #(.PC_W(PC_W), .LEN_W(LEN_W), .DISP_W(DISP_W), .CNT_W(CNT_W))
  i_branch_resolver (.*);

  function automatic logic flag_test(input logic [3:0] c, input logic s, z, p, cy, o);
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return o;          4'd5: return !o;
      4'd6: return p;          4'd7: return !p;
      4'd8: return 1'b0;       4'd9: return 1'b1;
      4'd10: return s != o;    4'd11: return s == o;
      4'd12: return (s != o) || z;
      4'd13: return !((s != o) || z);
      4'd14: return cy || z;   default: return !(cy || z);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] k, input logic [3:0] c);
    if (k == 2'd1) return "R6";
    if (k == 2'd2) return "R7";
    if (k == 2'd3) return "R8";
    if (c == 4'd8 || c == 4'd9) return "R1";
    if (c == 4'd2 || c == 4'd3 || c >= 4'd14) return "R4";
    if (c >= 4'd10) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic ok, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [3:0] c, input logic [4:0] f,
                       input logic [PC_W-1:0] pc, input logic [LEN_W-1:0] ln,
                       input logic [DISP_W-1:0] d, input logic [CNT_W-1:0] cn);
    exp_t e;
    logic ft;
    logic [CNT_W-1:0] dec;
    logic [PC_W-1:0] fall;
    @(negedge clk);
    kind_i = k; cond_i = c; {flag_s_i, flag_z_i, flag_p_i, flag_c_i, flag_o_i} = f;
    pc_i = pc; len_i = ln; disp_i = d; count_i = cn; eval_i = 1'b1;
    ft  = flag_test(c, f[4], f[3], f[2], f[1], f[0]);
    dec = cn - 1'b1;
    case (k)
      2'd0: begin e.tk = ft; e.cnt = cn; end
      2'd1: begin e.tk = (dec != 0); e.cnt = dec; end
      2'd2: begin e.tk = (cn == 0); e.cnt = cn; end
      default: begin e.tk = (dec != 0) && ft; e.cnt = dec; end
    endcase
    fall  = pc + {{(PC_W-LEN_W){1'b0}}, ln};
    e.npc = e.tk ? fall + {{(PC_W-DISP_W){d[DISP_W-1]}}, d} : fall;
    e.req = req_of(k, c);
    #1;
    check(e.req, taken_c_o === e.tk && count_c_o === e.cnt,
          $sformatf("comb k=%0d c=%0d f=%b cnt=%0d: taken=%b count=%0h exp taken=%b count=%0h",
                    k, c, f, cn, taken_c_o, count_c_o, e.tk, e.cnt));
    check("R5", next_pc_c_o === e.npc,
          $sformatf("next_pc=%h exp=%h", next_pc_c_o, e.npc));
    sb.push_back(e);
    pushes++;
    last_exp = e;
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      pulses++;
      if (sb.size() == 0) begin
        check("R9", 1'b0, "valid_o with empty scoreboard: act 1 exp 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R9", taken_o === e.tk && next_pc_o === e.npc && count_o === e.cnt,
              $sformatf("reg taken=%b pc=%h cnt=%h exp %b %h %h",
                        taken_o, next_pc_o, count_o, e.tk, e.npc, e.cnt));
      end
    end
  end

  initial begin
    #2_000_000;
    check("WDOG", 1'b0, "watchdog expired: act running exp done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", valid_o === 1'b0 && taken_o === 1'b0 && next_pc_o === '0 && count_o === '0,
          $sformatf("reset v=%b t=%b pc=%h c=%h exp all zero", valid_o, taken_o, next_pc_o, count_o));
    rst = 1'b0;

    // every code against every flag pattern, positive displacement (R1..R4, R5)
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        drive(2'd0, 4'(c), 5'(f), 32'h0000_1000 + 32'(f), 4'(1 + (f % 15)), 16'h0040, 16'd7);

    // negative displacement and address wrap (R5)
    drive(2'd0, 4'd9, 5'd0, 32'h0000_0010, 4'd2, 16'hFF00, 16'd0);
    drive(2'd0, 4'd9, 5'd0, 32'hFFFF_FFFE, 4'd4, 16'h0010, 16'd0);
    drive(2'd0, 4'd8, 5'd0, 32'hFFFF_FFFF, 4'd15, 16'h8000, 16'd0);
    drive(2'd0, 4'd9, 5'd0, 32'h0000_0004, 4'd3, 16'h8000, 16'd0);

    // count forms (R6, R7, R8)
    for (int k = 1; k < 4; k++)
      for (int cn = 0; cn < 4; cn++) begin
        drive(2'(k), 4'd0, 5'b01000, 32'h0000_2000, 4'd2, 16'hFFF0, 16'(cn));
        drive(2'(k), 4'd1, 5'b01000, 32'h0000_2000, 4'd2, 16'hFFF0, 16'(cn));
        drive(2'(k), 4'd8, 5'b00000, 32'h0000_3000, 4'd5, 16'h0100, 16'(cn));
      end
    drive(2'd1, 4'd9, 5'd0, 32'h0000_4000, 4'd2, 16'hFFFE, 16'hFFFF);
    drive(2'd3, 4'd14, 5'b00010, 32'h0000_4000, 4'd2, 16'hFFFE, 16'h0100);

    @(negedge clk);
    eval_i = 1'b0;
    kind_i = 2'd0; cond_i = 4'd9; pc_i = 32'h1234_5678; count_i = 16'hABCD;
    repeat (3) @(negedge clk);
    check("R9", valid_o === 1'b0 && taken_o === last_exp.tk && next_pc_o === last_exp.npc
                && count_o === last_exp.cnt,
          $sformatf("hold v=%b t=%b pc=%h c=%h exp 0 %b %h %h", valid_o, taken_o, next_pc_o,
                    count_o, last_exp.tk, last_exp.npc, last_exp.cnt));
    check("R9", pulses == pushes && sb.size() == 0,
          $sformatf("valid pulses=%0d exp=%0d", pulses, pushes));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule